// File: doc/BRIEF.md
# Master Serial Word Port with Transmit Pad Float Control

This block is the master end of a synchronous serial link. A parent loads a parallel word and pulses `start`. The block then shifts that word out on `txd`, most significant bit first, while it captures the same number of bits from `rxd`. It makes the serial clock `sclk` from the system clock through a programmable divider and frames the word with the active-low select `sfrm_n`. The word length can be set from 4 to 32 bits. When the word is finished, the received bits appear right-aligned on `rx_word`, and `done` pulses for one cycle.

There are two frame formats: SPI-style and Microwire-style. The parent also chooses whether the transmit pad may float. The output `txd_oe` tells the pad when to drive. In SPI-style with floating enabled, the pad drives only inside the frame, and a select input sets what the pad shows during the tail after the last falling clock edge. In Microwire-style with floating enabled, the pad starts to drive when the MSB is launched. It floats again at the rising clock edge during the LSB, unless the late-float option holds it driven until the frame closes. The late-float option is forced off in SPI-style.

The control is a state machine with six states:
- `ST_IDLE`: no frame.
- `ST_LEAD`: the frame is open and the clock is still low.
- `ST_HIGH`: the clock is high.
- `ST_LOW`: the clock is low between bits.
- `ST_TAIL`: after the last falling edge.
- `ST_DONE`: the frame has closed and `done` pulses.

The transitions are:
- IDLE→LEAD on an accepted start.
- LEAD→HIGH at the end of a half period.
- HIGH→LOW at the end of a half period, while bits remain.
- HIGH→TAIL at the end of a half period, after the last bit.
- LOW→HIGH at the end of a half period.
- TAIL→DONE at the end of a half period.
- DONE→IDLE unconditionally.

Top module: `ser_word_master`

## Requirements
- R1: The effective length L is `word_len`, clamped to the range 4 to W (values below 4 give 4, values above W give W). Bit L-1 of `tx_word` is on `txd` first and bit 0 last. Bits of `tx_word` above L-1 are never sent.
- R2: `sclk` idles low. Each half period lasts `clk_div`+1 system clocks. `sfrm_n` falls one half period before the first rising edge and rises one half period after the last falling edge. `txd` changes only at a falling edge or when the frame opens. `rxd` is sampled at each rising edge.
- R3: When `tristate_en`=0, `txd_oe` is 1 in every cycle.
- R4: In SPI-style (`fmt_sel`=0) with `tristate_en`=1, `txd_oe` equals the inverse of `sfrm_n`.
- R5: In SPI-style, during the tail half period, `txd` shows the LSB when `eod_sel`=0 and shows 0 when `eod_sel`=1. In Microwire-style the LSB is held in the tail.
- R6: In Microwire-style (`fmt_sel`=1) with `tristate_en`=1 and `late_float`=0, `txd_oe` is 1 from the opening of the frame until the rising edge during the LSB, and 0 from then on. With `late_float`=1, `txd_oe` is 1 for the whole frame.
- R7: In SPI-style, `late_float` has no effect on `txd_oe` or `txd`.
- R8: `done` is high for exactly one cycle, in the first cycle after `sfrm_n` returns high. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R9: `rx_word` holds the L captured bits, right-aligned, with the first captured bit in bit L-1 and zeros above. It changes only in the cycle where `done` is high.
- R10: A `start` while `busy` is ignored. Format, length, divider, tristate, late-float and end-of-data settings are taken at the accepted start, and changes to them while busy have no effect.
- R11: After reset, `sclk`=0, `sfrm_n`=1, `txd`=0, `txd_oe`=1, `busy`=0, `done`=0 and `rx_word`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a word; accepted only when idle |
| tx_word | input | W | Word to send, right-aligned |
| word_len | input | $clog2(W+1) | Requested word length in bits |
| clk_div | input | DIV_W | Half period of `sclk`, in system clocks, minus one |
| fmt_sel | input | 1 | 0 SPI-style, 1 Microwire-style |
| tristate_en | input | 1 | Allow the transmit pad to float |
| late_float | input | 1 | Microwire-style: keep the pad driven until the frame closes |
| eod_sel | input | 1 | SPI-style tail value: 0 holds the LSB, 1 drives 0 |
| rxd | input | 1 | Serial receive data |
| busy | output | 1 | A word is in progress |
| done | output | 1 | One-cycle pulse when the word is complete |
| rx_word | output | W | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| sfrm_n | output | 1 | Active-low frame select |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit pad output enable |

## Verification
The assertions check, on every cycle, the relations that hold whatever the stimulus:
- the pad is always driven when floating is off, and follows the frame in SPI-style;
- the clock is high only inside a frame, and `txd` holds while `sclk` stays high;
- `done` is a single pulse with the frame closed;
- `rx_word` moves only on `done`;
- the divider count never passes its limit.

The exact cycle in which the Microwire pad floats, the tail value chosen by `eod_sel`, the length clamp, the bit order of the sent and received data, and the ignored mid-word start and settings changes are shown only by the bench. The bench models the whole waveform arithmetically, cycle by cycle, across all format and option combinations, several lengths and two divider settings.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_DONE
    } ssm_state_e;

    typedef enum logic {
        FMT_SPI   = 1'b0,
        FMT_MWIRE = 1'b1
    } ssm_fmt_e;

    typedef struct packed {
        ssm_fmt_e fmt;
        logic     tri_en;
        logic     late;
        logic     eod;
    } ssm_cfg_t;

endpackage

// File: rtl/ssm_half_timer.sv
module ssm_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div)); // R2

endmodule

// File: rtl/ssm_shift_path.sv
module ssm_shift_path #(
    parameter int W     = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     word_in,
    input  logic [LEN_W-1:0] len,
    input  logic             shift_tx,
    input  logic             sample_rx,
    input  logic             rxd,
    output logic             tx_bit,
    output logic [W-1:0]     rx_bits
);
    localparam logic [LEN_W:0] W_L = (LEN_W+1)'(W);

    logic [W-1:0] tx_sh;

    assign tx_bit = tx_sh[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_bits <= '0;
        end else if (load) begin
            tx_sh   <= word_in << (W_L - {1'b0, len});
            rx_bits <= '0;
        end else begin
            if (shift_tx)
                tx_sh <= {tx_sh[W-2:0], 1'b0};
            if (sample_rx)
                rx_bits <= {rx_bits[W-2:0], rxd};
        end
    end

endmodule

// File: rtl/ssm_pad_ctl.sv
module ssm_pad_ctl
    import ssm_pkg::*;
(
    input  ssm_state_e st,
    input  ssm_cfg_t   cfg,
    input  logic       last_bit,
    input  logic       tx_bit,
    output logic       txd,
    output logic       txd_oe
);
    logic hold_all;

    assign hold_all = (cfg.fmt == FMT_SPI) || cfg.late;

    always_comb begin
        unique case (st)
            ST_LEAD, ST_HIGH, ST_LOW: txd = tx_bit;
            ST_TAIL:                  txd = (cfg.fmt == FMT_SPI && cfg.eod) ? 1'b0 : tx_bit;
            default:                  txd = 1'b0;
        endcase
    end

    always_comb begin
        if (!cfg.tri_en) begin
            txd_oe = 1'b1;
        end else begin
            unique case (st)
                ST_LEAD, ST_LOW: txd_oe = 1'b1;
                ST_HIGH:         txd_oe = hold_all || !last_bit;
                ST_TAIL:         txd_oe = hold_all;
                default:         txd_oe = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ser_word_master.sv
module ser_word_master
    import ssm_pkg::*;
#(
    parameter int W     = 32,
    parameter int DIV_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [W-1:0]             tx_word,
    input  logic [$clog2(W+1)-1:0]   word_len,
    input  logic [DIV_W-1:0]         clk_div,
    input  logic                     fmt_sel,
    input  logic                     tristate_en,
    input  logic                     late_float,
    input  logic                     eod_sel,
    input  logic                     rxd,
    output logic                     busy,
    output logic                     done,
    output logic [W-1:0]             rx_word,
    output logic                     sclk,
    output logic                     sfrm_n,
    output logic                     txd,
    output logic                     txd_oe
);
    localparam int LEN_W = $clog2(W+1);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(4);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(W);

    ssm_state_e       st, st_nx;
    ssm_cfg_t         cfg_q;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] bits_left, len_eff;
    logic             accept, run, tick, shift_tx, sample_rx, tx_bit, last_bit;
    logic [W-1:0]     rx_bits;

    assign accept    = (st == ST_IDLE) && start;
    assign run       = (st == ST_LEAD) || (st == ST_HIGH) || (st == ST_LOW) || (st == ST_TAIL);
    assign last_bit  = (bits_left == LEN_W'(1));
    assign sample_rx = tick && ((st == ST_LEAD) || (st == ST_LOW));
    assign shift_tx  = tick && (st == ST_HIGH) && !last_bit;

    always_comb begin
        if (word_len < LEN_MIN)      len_eff = LEN_MIN;
        else if (word_len > LEN_MAX) len_eff = LEN_MAX;
        else                         len_eff = word_len;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_LEAD;
            ST_LEAD: if (tick)  st_nx = ST_HIGH;
            ST_HIGH: if (tick)  st_nx = last_bit ? ST_TAIL : ST_LOW;
            ST_LOW:  if (tick)  st_nx = ST_HIGH;
            ST_TAIL: if (tick)  st_nx = ST_DONE;
            ST_DONE:            st_nx = ST_IDLE;
            default:            st_nx = ST_IDLE;
        endcase
    end

    // settings captured at start, bit counter, received word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            div_q     <= '0;
            bits_left <= '0;
            rx_word   <= '0;
        end else begin
            if (accept) begin
                cfg_q.fmt    <= ssm_fmt_e'(fmt_sel);
                cfg_q.tri_en <= tristate_en;
                cfg_q.late   <= late_float && fmt_sel;   // forced off in SPI-style
                cfg_q.eod    <= eod_sel;
                div_q        <= clk_div;
                bits_left    <= len_eff;
            end else if (tick && st == ST_HIGH) begin
                bits_left <= bits_left - 1'b1;
            end
            if (tick && st == ST_TAIL)
                rx_word <= rx_bits;
        end
    end

    // outputs
    always_comb begin
        busy   = (st != ST_IDLE);
        done   = (st == ST_DONE);
        sclk   = (st == ST_HIGH);
        sfrm_n = !run;
    end

    ssm_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div_q),
        .tick (tick)
    );

    ssm_shift_path #(.W(W), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .word_in  (tx_word),
        .len      (len_eff),
        .shift_tx (shift_tx),
        .sample_rx(sample_rx),
        .rxd      (rxd),
        .tx_bit   (tx_bit),
        .rx_bits  (rx_bits)
    );

    ssm_pad_ctl u_pad (
        .st      (st),
        .cfg     (cfg_q),
        .last_bit(last_bit),
        .tx_bit  (tx_bit),
        .txd     (txd),
        .txd_oe  (txd_oe)
    );

    AST_NO_TRI_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.tri_en |-> txd_oe); // R3
    AST_SPI_FRAME_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.fmt == FMT_SPI && cfg_q.tri_en) |-> (txd_oe == !sfrm_n)); // R4
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !sfrm_n); // R2
    AST_TXD_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(txd)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_FRAME_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sfrm_n && !sclk && busy)); // R8
    AST_RX_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> done); // R9
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R10

endmodule

// File: tb/sim_ser_word_master.sv
module sim_ser_word_master;
    localparam int W  = 32;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  tx_word = '0;
    logic [5:0]    word_len = '0;
    logic [DW-1:0] clk_div = '0;
    logic          fmt_sel = 1'b0, tristate_en = 1'b0, late_float = 1'b0, eod_sel = 1'b0;
    logic          rxd = 1'b0;
    logic          busy, done, sclk, sfrm_n, txd, txd_oe;
    logic [W-1:0]  rx_word;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] prev_rx = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    ser_word_master #(.W(W), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .word_len(word_len), .clk_div(clk_div), .fmt_sel(fmt_sel),
        .tristate_en(tristate_en), .late_float(late_float), .eod_sel(eod_sel),
        .rxd(rxd), .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk),
        .sfrm_n(sfrm_n), .txd(txd), .txd_oe(txd_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic xfer(input bit f, input bit t, input bit l, input bit e,
                        input int lenin, input int dv,
                        input logic [31:0] word, input logic [31:0] rpat);
        int L, H, last_k;
        logic [31:0] mask;
        L = (lenin < 4) ? 4 : (lenin > 32) ? 32 : lenin;
        H = dv + 1;
        mask = (L == 32) ? 32'hFFFF_FFFF : ((32'h1 << L) - 1);
        last_k = (2*L + 1) * H + 1;
        @(negedge clk);
        fmt_sel = f; tristate_en = t; late_float = l; eod_sel = e;
        word_len = lenin[5:0]; clk_div = DW'(dv); tx_word = word; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: scramble every setting once the word is under way
        fmt_sel = !f; tristate_en = !t; late_float = !l; eod_sel = !e;
        word_len = 6'd7; clk_div = DW'(3); tx_word = ~word;
        for (int k = 0; k <= last_k; k++) begin
            int p;
            bit in_fr, is_done;
            logic e_sclk, e_txd, e_oe;
            string oe_tag;
            p = k / H;
            in_fr = (k < last_k - 1);
            is_done = (k == last_k - 1);
            e_sclk = in_fr && p[0] && (p <= 2*L - 1);
            if (!in_fr)          e_txd = 1'b0;
            else if (p < 2*L)    e_txd = word[L - 1 - p/2];
            else                 e_txd = (!f && e) ? 1'b0 : word[0];
            if (!t)              begin e_oe = 1'b1; oe_tag = "R3"; end
            else if (!in_fr)     begin e_oe = 1'b0; oe_tag = f ? "R6" : "R4"; end
            else if (!f)         begin e_oe = 1'b1; oe_tag = l ? "R7" : "R4"; end
            else if (l)          begin e_oe = 1'b1; oe_tag = "R6"; end
            else                 begin e_oe = (p < 2*L - 1); oe_tag = "R6"; end
            check("R2 sclk", {31'b0, sclk}, {31'b0, e_sclk});
            check("R2 sfrm_n", {31'b0, sfrm_n}, {31'b0, !in_fr});
            check((in_fr && p == 2*L) ? "R5 txd tail" : "R1 txd", {31'b0, txd}, {31'b0, e_txd});
            check({oe_tag, " txd_oe"}, {31'b0, txd_oe}, {31'b0, e_oe});
            check("R8 done", {31'b0, done}, {31'b0, is_done});
            check("R10 busy", {31'b0, busy}, {31'b0, (k < last_k)});
            if (k < last_k - 1) check("R9 rx_word held", rx_word, prev_rx);
            else                check("R9 rx_word", rx_word, rpat & mask);
            // drive receive data for the next rising edge
            if (in_fr && !p[0] && p < 2*L) rxd = rpat[L - 1 - p/2];
            else                           rxd = ~rxd;
            start = (k == 3);   // R10: ignored while busy
            @(negedge clk);
        end
        start = 1'b0;
        prev_rx = rpat & mask;
    endtask

    initial begin
        int lens[6];
        lens = '{0, 4, 5, 9, 32, 40};
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 sclk", {31'b0, sclk}, 32'd0);
        check("R11 sfrm_n", {31'b0, sfrm_n}, 32'd1);
        check("R11 txd", {31'b0, txd}, 32'd0);
        check("R11 txd_oe", {31'b0, txd_oe}, 32'd1);
        check("R11 busy", {31'b0, busy}, 32'd0);
        check("R11 done", {31'b0, done}, 32'd0);
        check("R11 rx_word", rx_word, 32'd0);
        rst_n = 1'b1;
        for (int f = 0; f < 2; f++)
            for (int t = 0; t < 2; t++)
                for (int l = 0; l < 2; l++)
                    for (int e = 0; e < 2; e++)
                        for (int li = 0; li < 6; li++)
                            for (int dv = 0; dv <= 2; dv += 2) begin
                                logic [31:0] w, r;
                                w = next_rand();
                                r = next_rand();
                                xfer(f[0], t[0], l[0], e[0], lens[li], dv, w, r);
                            end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule